// File: doc/BRIEF.md
# General-Purpose I/O Port with Level Check

This block is one byte-wide I/O port of a microcontroller. It holds an output latch and three configuration registers: a per-bit direction register, a per-bit select that gives the pin to an internal peripheral instead of the latch, and a pull-up option register. The port's pull-up enable is one bit of that option register. Pin inputs pass through a two-stage synchronizer before anything inside the block uses them.

Software reaches the port through a small register bus with a 3-bit offset. A port write loads the whole latch. A dedicated bit operation sets or clears one latch bit and leaves the others alone. A second bit operation models a byte-wide read-modify-write: the current port readback, with one bit replaced, is written back into the latch, so latch bits of input-mode or control-mode pins take whatever the readback held. A check strobe compares each driven pin with the level it should carry and registers a single match flag.

The output latch has no reset. After reset every driver is off and every pull-up is disconnected, but the latch keeps its earlier contents. An input-only build option forces every bit to input mode.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and after it is released, `pin_oe` and `pin_pu` are all zero, and reads of offsets 1, 2 and 3 return 0x00 until they are written.
- R2: Reset leaves the output latch unchanged. A latch value written before reset is driven again once the bits are set to output mode after reset.
- R3: Bit 7 of the pull-up option register (offset 3) always reads 0. Writing 1 to it has no effect on the readback or on `pin_pu`.
- R4: `pin_pu[i]` is 1 only when option bit PU_BIT is set, bit i is in input mode, and `ext_bus` is low.
- R5: `pin_oe` equals the direction register (1 = output, offset 1). `pin_out[i]` carries `periph_out[i]` when control-select bit i (offset 2) is 1, and latch bit i otherwise.
- R6: A read of offset 0 returns the synchronized pin level for input-mode bits, `periph_out` for output bits in control mode, and the latch for output bits in port mode. A pin change shows up in this read after two rising clock edges. Offset 0 writes load the whole latch.
- R7: A write to offset 4 sets latch bit `wdata[2:0]` to `wdata[3]`. All other latch bits are left unchanged.
- R8: A write to offset 5 loads the latch with the offset-0 readback of that cycle, with bit `wdata[2:0]` replaced by `wdata[3]`.
- R9: When `chk_stb` is high at a rising edge, `chk_match` becomes 1 at that edge exactly when every output-mode bit's synchronized pin level equals its driven level (the peripheral level in control mode, the latch otherwise). Input-mode bits always match. Without a strobe, `chk_match` holds its value.
- R10: With INPUT_ONLY set, the direction register reads 0 and `pin_oe` stays 0 whatever is written, and every check reports a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| chk_stb | input | 1 | Start a pin-versus-intended-level check |
| chk_match | output | 1 | Registered result of the last check |
| ext_bus | input | 1 | Port lent to an external bus; pull-ups are withheld |
| periph_out | input | 8 | Peripheral levels for control-mode bits |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_oe | output | 8 | Per-bit output driver enable |
| pin_pu | output | 8 | Per-bit pull-up enable |

## Verification
The offset-0 readback is tested with mixed ports: some bits in input mode, some in control mode and some in port mode at once. Each group has a distinct value, so a wrong source selection for any class shows up. The two bit operations are run on the same mixed configuration. The dedicated set/clear must leave neighbour bits intact, while the read-modify-write must copy pin and peripheral levels into the latch. The check is tried with all-matching pins, a one-bit mismatch, all bits in input mode, and a control-mode bit. A behavioural reference model is also compared against every output on every clock.

// File: rtl/gpio_pkg.sv
// Shared register offsets for the I/O port.
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT   = 3'd0,
        REG_DIR    = 3'd1,
        REG_CSEL   = 3'd2,
        REG_PULL   = 3'd3,
        REG_BITSC  = 3'd4,
        REG_BITRMW = 3'd5
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes STAGES >= 2; all stages clear on reset.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the pin sample through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-bit pin routing: driven level, driver enable, pull-up, readback
// source and per-bit check result. Purely combinational.
// Assumes pin_s is already synchronized.
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] csel,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] periph,
    input  logic [W-1:0] pin_s,
    input  logic         pull_en,
    output logic [W-1:0] drv,
    output logic [W-1:0] oe,
    output logic [W-1:0] pu,
    output logic [W-1:0] rdback,
    output logic [W-1:0] bit_ok
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic lvl;
        // intended level: peripheral in control mode, latch otherwise
        always_comb lvl = csel[i] ? periph[i] : latch[i];
        assign drv[i]    = lvl;
        assign oe[i]     = dir[i];
        assign pu[i]     = pull_en & ~dir[i];
        assign rdback[i] = dir[i] ? lvl : pin_s[i];
        assign bit_ok[i] = ~dir[i] | (pin_s[i] == lvl);
    end
endmodule

// File: rtl/gpio_check.sv
// Registers the AND of per-bit check results when strobed.
// The result holds between strobes and clears on reset.
module gpio_check #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] bit_ok,
    output logic         match_q
);
    // capture the combined result on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n)   match_q <= 1'b0;
        else if (stb) match_q <= &bit_ok;
    end
endmodule

// File: rtl/gpio_port.sv
// Byte-wide I/O port: output latch (not reset), direction, control
// select, pull-up option register, two bit operations and a pin check.
// Assumes W is a power of two and PU_BIT differs from PU_FIXED.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W          = 8,
    parameter int PU_BIT     = 0,
    parameter int PU_FIXED   = 7,
    parameter bit INPUT_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              chk_stb,
    output logic              chk_match,
    input  logic              ext_bus,
    input  logic [W-1:0]      periph_out,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu
);
    localparam int IDX_W = $clog2(W);
    localparam logic [W-1:0] PULL_MASK = ~(W'(1) << PU_FIXED);

    logic [W-1:0]     latch_q, dir_q, csel_q, pull_q;
    logic [W-1:0]     pin_s, rdback, bit_ok, rmw_val;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;
    logic             wr_port, wr_dir, wr_csel, wr_pull, wr_sc, wr_rmw;

    assign bit_idx = bus_wdata[IDX_W-1:0];
    assign bit_val = bus_wdata[IDX_W];
    assign wr_port = bus_wr && (bus_addr == REG_PORT);
    assign wr_dir  = bus_wr && (bus_addr == REG_DIR);
    assign wr_csel = bus_wr && (bus_addr == REG_CSEL);
    assign wr_pull = bus_wr && (bus_addr == REG_PULL);
    assign wr_sc   = bus_wr && (bus_addr == REG_BITSC);
    assign wr_rmw  = bus_wr && (bus_addr == REG_BITRMW);

    gpio_sync #(.W(W), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    gpio_pin_mux #(.W(W)) mux_i (
        .dir(dir_q), .csel(csel_q), .latch(latch_q), .periph(periph_out),
        .pin_s(pin_s), .pull_en(pull_q[PU_BIT] & ~ext_bus),
        .drv(pin_out), .oe(pin_oe), .pu(pin_pu),
        .rdback(rdback), .bit_ok(bit_ok)
    );

    gpio_check #(.W(W)) check_i (
        .clk(clk), .rst_n(rst_n), .stb(chk_stb),
        .bit_ok(bit_ok), .match_q(chk_match)
    );

    // read-modify-write value: readback with the addressed bit replaced
    always_comb begin
        rmw_val          = rdback;
        rmw_val[bit_idx] = bit_val;
    end

    // output latch: deliberately no reset
    always_ff @(posedge clk) begin
        if (wr_port)     latch_q          <= bus_wdata;
        else if (wr_sc)  latch_q[bit_idx] <= bit_val;
        else if (wr_rmw) latch_q          <= rmw_val;
    end

    if (INPUT_ONLY) begin : g_dir_fixed
        assign dir_q = '0;
    end else begin : g_dir_reg
        // direction register
        always_ff @(posedge clk) begin
            if (!rst_n)      dir_q <= '0;
            else if (wr_dir) dir_q <= bus_wdata;
        end
    end

    // control select and pull-up option registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_q <= '0;
            pull_q <= '0;
        end else begin
            if (wr_csel) csel_q <= bus_wdata;
            if (wr_pull) pull_q <= bus_wdata & PULL_MASK;
        end
    end

    // read data select
    always_comb begin
        case (bus_addr)
            REG_PORT: bus_rdata = rdback;
            REG_DIR:  bus_rdata = dir_q;
            REG_CSEL: bus_rdata = csel_q;
            REG_PULL: bus_rdata = pull_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind below.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int W          = 8,
    parameter int PU_FIXED   = 7,
    parameter bit INPUT_ONLY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              chk_stb,
    input logic              chk_match,
    input logic              ext_bus,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_pu,
    input logic [W-1:0]      latch_q
);
    localparam int IDX_W = $clog2(W);
    logic [W-1:0] keep_mask;
    logic         sc_wr;
    assign keep_mask = ~(W'(1) << bus_wdata[IDX_W-1:0]);
    assign sc_wr     = bus_wr && (bus_addr == REG_BITSC);

    // R4
    pull_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & (pin_oe | {W{ext_bus}})) == '0);

    // R3
    pull_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_PULL) |-> (bus_rdata[PU_FIXED] == 1'b0));

    // R7
    bitsc_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr |=> (((latch_q ^ $past(latch_q)) & $past(keep_mask)) == '0));

    // R7
    bitsc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr |=> (latch_q[$past(bus_wdata[IDX_W-1:0])] == $past(bus_wdata[IDX_W])));

    // R9
    input_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_stb && pin_oe == '0) |=> chk_match);

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_stb |=> $stable(chk_match));

    if (INPUT_ONLY) begin : g_ro
        // R10
        ro_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe == '0);
    end
endmodule

bind gpio_port gpio_port_chk #(.W(W), .PU_FIXED(PU_FIXED), .INPUT_ONLY(INPUT_ONLY)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chk_stb(chk_stb),
    .chk_match(chk_match), .ext_bus(ext_bus), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .latch_q(latch_q)
);

// File: tb/gpio_port_tb_top.sv
// Bench for gpio_port: directed checks plus a per-clock behavioural model.
module gpio_port_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 0, rst_n = 0, bus_wr = 0, chk_stb = 0, ext_bus = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, periph_out = 0, pin_in = 0;
    logic [7:0] bus_rdata, pin_out, pin_oe, pin_pu;
    logic       chk_match;
    logic [7:0] ro_rdata, ro_out, ro_oe, ro_pu;
    logic       ro_match;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chk_stb(chk_stb),
        .chk_match(chk_match), .ext_bus(ext_bus), .periph_out(periph_out),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    gpio_port #(.INPUT_ONLY(1'b1)) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(ro_rdata), .chk_stb(chk_stb),
        .chk_match(ro_match), .ext_bus(ext_bus), .periph_out(periph_out),
        .pin_in(pin_in), .pin_out(ro_out), .pin_oe(ro_oe), .pin_pu(ro_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_latch = 0, m_lv = 0, m_dir = 0, m_csel = 0, m_pull = 0;
    logic [7:0] m_rd;
    logic       m_match = 0;
    logic [7:0] m_sync[$] = '{8'h00, 8'h00};

    function automatic logic [7:0] lvl_of(input int i);
        return m_csel[i] ? periph_out[i] : m_latch[i];
    endfunction

    function automatic logic [7:0] model_rd();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_dir[i] ? lvl_of(i) : m_sync[1][i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_csel = 0; m_pull = 0; m_match = 0;
            m_sync = '{8'h00, 8'h00};
        end else begin
            m_rd = model_rd();
            if (chk_stb) begin
                m_match = 1;
                for (int i = 0; i < 8; i++)
                    if (m_dir[i] && (m_sync[1][i] != lvl_of(i))) m_match = 0;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_latch = bus_wdata; m_lv = 8'hFF; end
                    3'd1: m_dir = bus_wdata;
                    3'd2: m_csel = bus_wdata;
                    3'd3: m_pull = bus_wdata & 8'h7F;
                    3'd4: begin
                        m_latch[bus_wdata[2:0]] = bus_wdata[3];
                        m_lv[bus_wdata[2:0]] = 1'b1;
                    end
                    3'd5: begin
                        m_lv = m_lv | ~m_dir | m_csel;
                        m_lv[bus_wdata[2:0]] = 1'b1;
                        m_latch = m_rd;
                        m_latch[bus_wdata[2:0]] = bus_wdata[3];
                    end
                    default: ;
                endcase
            end
            void'(m_sync.pop_back());
            m_sync.push_front(pin_in);
        end
    end

    // per-clock comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            logic [7:0] care, e_rd;
            care = m_csel | m_lv;
            chk("R5 model pin_oe", pin_oe, m_dir);
            chk("R5 model pin_out", pin_out & care,
                ((periph_out & m_csel) | (m_latch & ~m_csel)) & care);
            chk("R4 model pin_pu", pin_pu, (m_pull[0] && !ext_bus) ? ~m_dir : 8'h00);
            chk("R9 model chk_match", {7'd0, chk_match}, {7'd0, m_match});
            case (bus_addr)
                3'd0: begin
                    care = ~m_dir | m_csel | m_lv;
                    chk("R6 model port read", bus_rdata & care, model_rd() & care);
                end
                3'd1: e_rd = m_dir;
                3'd2: e_rd = m_csel;
                3'd3: e_rd = m_pull;
                default: e_rd = 8'h00;
            endcase
            if (bus_addr != 3'd0) chk("R1 model reg read", bus_rdata, e_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic strobe();
        @(negedge clk); chk_stb = 1;
        @(negedge clk); chk_stb = 0;
        #1;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: outputs and registers after reset
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_pu", pin_pu, 8'h00);
        rst_n = 1;
        rd(3'd1, 8'h00, "R1 dir read");
        rd(3'd2, 8'h00, "R1 csel read");
        rd(3'd3, 8'h00, "R1 pull read");

        // R5: port-mode drive
        wr(3'd0, 8'hA5); wr(3'd1, 8'hFF);
        chk("R5 oe follows dir", pin_oe, 8'hFF);
        chk("R5 latch driven", pin_out, 8'hA5);

        // R2: latch survives reset
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 oe off in reset", pin_oe, 8'h00);
        rst_n = 1;
        wr(3'd1, 8'hFF);
        rd(3'd0, 8'hA5, "R2 latch kept");
        chk("R2 latch driven", pin_out, 8'hA5);

        // R3: fixed bit in pull-up option register
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'h7F, "R3 bit7 reads 0");
        wr(3'd3, 8'h80);
        rd(3'd3, 8'h00, "R3 bit7 write ignored");
        wr(3'd1, 8'h00);
        chk("R3 no pull from bit7", pin_pu, 8'h00);

        // R4: pull-up gating
        wr(3'd1, 8'h0F); wr(3'd3, 8'h01);
        #1; chk("R4 pull on inputs", pin_pu, 8'hF0);
        @(negedge clk); ext_bus = 1; #1;
        chk("R4 pull off for ext bus", pin_pu, 8'h00);
        @(negedge clk); ext_bus = 0;
        wr(3'd3, 8'h00);
        chk("R4 pull off when disabled", pin_pu, 8'h00);

        // R5: control-mode drive
        wr(3'd1, 8'hFF); wr(3'd2, 8'h0F);
        @(negedge clk); periph_out = 8'h3C; #1;
        chk("R5 control mix", pin_out, 8'hAC);

        // R6: mixed readback sources and synchronizer latency
        wr(3'd1, 8'hF0); wr(3'd2, 8'h30);
        @(negedge clk); pin_in = 8'h96;
        settle();
        rd(3'd0, 8'hB6, "R6 mixed read");
        @(negedge clk); pin_in = 8'h99; bus_addr = 0; #1;
        @(negedge clk); #1;
        chk("R6 one edge old", bus_rdata, 8'hB6);
        @(negedge clk); #1;
        chk("R6 two edges new", bus_rdata, 8'hB9);

        // R7: dedicated bit set/clear
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd0, 8'hA5);
        wr(3'd4, 8'h0B);
        rd(3'd0, 8'hAD, "R7 set bit3");
        wr(3'd4, 8'h07);
        rd(3'd0, 8'h2D, "R7 clear bit7");

        // R8: read-modify-write corrupts input/control bits
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h0F); wr(3'd2, 8'h03);
        @(negedge clk); periph_out = 8'h01; pin_in = 8'hF0;
        settle();
        wr(3'd5, 8'h0A);
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
        rd(3'd0, 8'hF5, "R8 rmw writeback");

        // R9: check operation
        @(negedge clk); pin_in = 8'hF5;
        settle();
        strobe(); chk("R9 full match", {7'd0, chk_match}, 8'h01);
        @(negedge clk); pin_in = 8'hF4;
        settle();
        chk("R9 held without strobe", {7'd0, chk_match}, 8'h01);
        strobe(); chk("R9 one-bit mismatch", {7'd0, chk_match}, 8'h00);
        wr(3'd1, 8'h00);
        strobe(); chk("R9 inputs always match", {7'd0, chk_match}, 8'h01);
        wr(3'd1, 8'h01); wr(3'd2, 8'h01);
        @(negedge clk); periph_out = 8'h01; pin_in = 8'h01;
        settle();
        strobe(); chk("R9 control bit match", {7'd0, chk_match}, 8'h01);
        @(negedge clk); periph_out = 8'h00;
        strobe(); chk("R9 control bit mismatch", {7'd0, chk_match}, 8'h00);

        // R10: input-only build
        wr(3'd1, 8'hFF);
        #1;
        chk("R10 no drive", ro_oe, 8'h00);
        @(negedge clk); bus_addr = 3'd1; #1;
        chk("R10 dir reads 0", ro_rdata, 8'h00);
        @(negedge clk); pin_in = 8'h00; bus_addr = 0;
        settle();
        strobe(); chk("R10 check always matches", {7'd0, ro_match}, 8'h01);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule